// File: doc/BRIEF.md
# I2C Slave Byte Memory With Timed Commit

This block is the serial front end of a small byte-addressed memory that a bus master reaches over a two-wire I2C bus. It watches the clock and data lines with its own system clock, finds the start and stop conditions, and decodes the traffic into reads and writes of an internal array of 2048 bytes. The slave never drives a line high. It pulls the data line low through an output-enable pin, and the pad and pull-up turn that into an open-drain signal.

Every transfer opens with a select byte. Its upper nibble is a fixed device code, its next three bits are the top three bits of an 11-bit byte address, and its lowest bit gives the direction. A write carries one more byte holding the low eight address bits, then any number of data bytes. A read sends bytes from the current address pointer. The pointer advances after every data byte and wraps at the top of the array. A random read is done with a write that carries only the address, followed by a repeated start and a read select.

When a write transfer that stored data ends with a stop, the block models a non-volatile commit. A `busy` output stays high for a fixed, parameterised number of clocks. While `busy` is high the slave ignores start conditions.

Top module: `i2cm_slave`

## Requirements
- R1: After reset `sda_oe` is 0 (data line released) and `busy` is 0.
- R2: A select byte whose four upper bits are 1010 is acknowledged: `sda_oe` is 1 during the ninth clock. Any other upper nibble gets no acknowledge, and no byte after it is acknowledged until the next start.
- R3: A select byte with bit 0 = 0 starts a write. The following address byte and every data byte are acknowledged. The first data byte is stored at address {select[3:1], address byte}, where select bit 3 is address bit 10.
- R4: Bytes in both directions are shifted most significant bit first.
- R5: A select byte with bit 0 = 1 starts a read. The pointer takes its bits 10..8 from select[3:1] and keeps its low eight bits. Each byte is sent MSB first, and the slave releases the data line during the master's acknowledge clock.
- R6: The address pointer increments after each data byte, in reads and writes, and wraps from 2047 to 0.
- R7: If the master does not acknowledge a read byte, the slave stops driving and sends nothing more until the next start.
- R8: A stop that ends a write in which at least one data byte was stored raises `busy` two clocks after the stop is detected. `busy` then stays high for exactly NV_CYCLES clocks.
- R9: While `busy` is high a start is ignored, so a following select byte is not acknowledged, and the slave never drives the data line.
- R10: A stop after a read, or after a write that carried no data bytes, leaves `busy` at 0.
- R11: Bits clocked in before any start condition are never acknowledged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls the data line low; 0 releases it |
| busy | output | 1 | High while the modelled non-volatile commit runs |

## Verification
The hardest situation to reach is a start that arrives while the commit interval is still running. Only a stop that ends a write with stored data starts that interval, and a start is only ignored if it lands inside it. The bench runs with a commit interval longer than a start plus one full byte. It issues the new start and select byte directly after the stop of a one-byte write, then checks for a missing acknowledge and repeats the same select once `busy` has fallen. The wrap from the last address to the first is reached by pointing a two-byte write and a two-byte read at address 2047.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;
   typedef enum logic [2:0] {
      PH_IDLE,
      PH_SEL,
      PH_ADR,
      PH_WR,
      PH_RD
   } phase_t;
endpackage

// File: rtl/i2cm_sync.sv
module i2cm_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);
   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '1;
      else        chain <= {chain[STAGES-2:0], d_i};
   end

   assign q_o = chain[STAGES-1];
endmodule

// File: rtl/i2cm_linemon.sv
module i2cm_linemon #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);
   localparam int NLINES = 2;

   logic [NLINES-1:0] raw, syn, prev;

   assign raw = {scl_i, sda_i};

   genvar g;
   generate
      for (g = 0; g < NLINES; g++) begin : g_line
         i2cm_sync #(.STAGES(STAGES)) u_sync (
            .clk  (clk),
            .rst_n(rst_n),
            .d_i  (raw[g]),
            .q_o  (syn[g])
         );
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev <= '1;
      else        prev <= syn;
   end

   logic scl_s, scl_q, sda_q;
   assign scl_s = syn[1];
   assign scl_q = prev[1];
   assign sda_s = syn[0];
   assign sda_q = prev[0];

   assign scl_rise  = scl_s & ~scl_q;
   assign scl_fall  = ~scl_s & scl_q;
   assign start_det = scl_s & scl_q & sda_q & ~sda_s;
   assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/i2cm_nvtimer.sv
module i2cm_nvtimer #(
   parameter int CYCLES = 5000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic go_i,
   output logic busy_o
);
   localparam int CW = $clog2(CYCLES + 1);

   logic [CW-1:0] left;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          left <= '0;
      else if (go_i)       left <= CW'(CYCLES);
      else if (left != '0) left <= left - CW'(1);
   end

   assign busy_o = (left != '0);
endmodule

// File: rtl/i2cm_store.sv
module i2cm_store #(
   parameter int AW = 11
) (
   input  logic          clk,
   input  logic          we_i,
   input  logic [AW-1:0] waddr_i,
   input  logic [7:0]    wdata_i,
   input  logic [AW-1:0] raddr_i,
   output logic [7:0]    rdata_o
);
   localparam int DEPTH = 1 << AW;

   logic [7:0] cells [DEPTH];

   always_ff @(posedge clk) begin
      if (we_i) cells[waddr_i] <= wdata_i;
   end

   assign rdata_o = cells[raddr_i];
endmodule

// File: rtl/i2cm_slave.sv
module i2cm_slave
   import i2cm_pkg::*;
#(
   parameter int         SYNC_STAGES = 2,
   parameter int         SEL_HI_BITS = 3,
   parameter logic [3:0] DEV_CODE    = 4'b1010,
   parameter int         NV_CYCLES   = 5000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic sda_oe,
   output logic busy
);
   localparam int            AW  = 8 + SEL_HI_BITS;
   localparam logic [AW-1:0] ONE = AW'(1);

   generate
      if (SEL_HI_BITS < 1 || SEL_HI_BITS > 3) begin : g_bad_hi
         $error("SEL_HI_BITS must lie in 1..3");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
      if (NV_CYCLES < 1) begin : g_bad_nv
         $error("NV_CYCLES must be at least 1");
      end
   endgenerate

   logic sda_s, scl_rise, scl_fall, start_det, stop_det;

   i2cm_linemon #(.STAGES(SYNC_STAGES)) u_mon (
      .clk      (clk),
      .rst_n    (rst_n),
      .scl_i    (scl_i),
      .sda_i    (sda_i),
      .sda_s    (sda_s),
      .scl_rise (scl_rise),
      .scl_fall (scl_fall),
      .start_det(start_det),
      .stop_det (stop_det)
   );

   phase_t        ph, ph_nxt;
   logic [3:0]    bcnt;
   logic [7:0]    rx, tx;
   logic [AW-1:0] ptr;
   logic          mnack, wr_pend, oe_q, nv_go;
   logic [7:0]    rdata;
   logic          take_start, mem_we;

   assign take_start = start_det & ~busy;
   assign mem_we     = (ph == PH_WR) && scl_fall && (bcnt == 4'd8)
                       && !take_start && !stop_det;

   i2cm_store #(.AW(AW)) u_store (
      .clk    (clk),
      .we_i   (mem_we),
      .waddr_i(ptr),
      .wdata_i(rx),
      .raddr_i(ptr),
      .rdata_o(rdata)
   );

   i2cm_nvtimer #(.CYCLES(NV_CYCLES)) u_nv (
      .clk   (clk),
      .rst_n (rst_n),
      .go_i  (nv_go),
      .busy_o(busy)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph      <= PH_IDLE;
         ph_nxt  <= PH_IDLE;
         bcnt    <= '0;
         rx      <= '0;
         tx      <= '0;
         ptr     <= '0;
         mnack   <= 1'b1;
         wr_pend <= 1'b0;
         oe_q    <= 1'b0;
         nv_go   <= 1'b0;
      end else begin
         nv_go <= 1'b0;
         if (take_start) begin
            ph   <= PH_SEL;
            bcnt <= '0;
            oe_q <= 1'b0;
         end else if (stop_det) begin
            ph   <= PH_IDLE;
            oe_q <= 1'b0;
            if (wr_pend) begin
               nv_go   <= 1'b1;
               wr_pend <= 1'b0;
            end
         end else if (ph != PH_IDLE) begin
            if (scl_rise) begin
               if (bcnt < 4'd8) begin
                  bcnt <= bcnt + 4'd1;
                  if (ph != PH_RD) rx <= {rx[6:0], sda_s};
               end else if (bcnt == 4'd8) begin
                  bcnt <= 4'd9;
                  if (ph == PH_RD) mnack <= sda_s;
               end
            end else if (scl_fall) begin
               if (ph == PH_RD && bcnt >= 4'd1 && bcnt <= 4'd7) begin
                  oe_q <= ~tx[3'(4'd7 - bcnt)];
               end else if (bcnt == 4'd8) begin
                  case (ph)
                     PH_SEL: begin
                        if (rx[7:4] == DEV_CODE) begin
                           oe_q          <= 1'b1;
                           ptr[AW-1:8]   <= rx[SEL_HI_BITS:1];
                           ph_nxt        <= rx[0] ? PH_RD : PH_ADR;
                        end else begin
                           ph <= PH_IDLE;
                        end
                     end
                     PH_ADR: begin
                        oe_q      <= 1'b1;
                        ptr[7:0]  <= rx;
                        ph_nxt    <= PH_WR;
                     end
                     PH_WR: begin
                        oe_q    <= 1'b1;
                        ptr     <= ptr + ONE;
                        wr_pend <= 1'b1;
                        ph_nxt  <= PH_WR;
                     end
                     default: oe_q <= 1'b0;
                  endcase
               end else if (bcnt == 4'd9) begin
                  bcnt <= '0;
                  if (ph == PH_RD && mnack) begin
                     ph   <= PH_IDLE;
                     oe_q <= 1'b0;
                  end else if (ph_nxt == PH_RD) begin
                     tx   <= rdata;
                     ptr  <= ptr + ONE;
                     oe_q <= ~rdata[7];
                     ph   <= PH_RD;
                  end else begin
                     oe_q <= 1'b0;
                     ph   <= ph_nxt;
                  end
               end
            end
         end
      end
   end

   assign sda_oe = oe_q;
endmodule

// File: rtl/i2cm_slave_chk.sv
module i2cm_slave_chk #(
   parameter int NV_CYCLES = 5000
) (
   input logic clk,
   input logic rst_n,
   input logic scl_i,
   input logic sda_oe,
   input logic busy,
   input logic stop_det
);
   localparam int CW = $clog2(NV_CYCLES + 2) + 1;

   logic [CW-1:0] run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    run <= '0;
      else if (busy) run <= run + CW'(1);
      else           run <= '0;
   end

   // R4
   oe_moves_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sda_oe) |-> !scl_i);

   // R9
   quiet_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !sda_oe);

   // R8
   busy_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(stop_det, 2));

   // R8
   busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      run <= CW'(NV_CYCLES));
endmodule

bind i2cm_slave i2cm_slave_chk #(.NV_CYCLES(NV_CYCLES)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .scl_i   (scl_i),
   .sda_oe  (sda_oe),
   .busy    (busy),
   .stop_det(stop_det)
);

// File: tb/i2cm_slave_bench.sv
module i2cm_slave_bench;
   localparam int NV = 400;
   localparam int Q  = 6;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic scl = 1'b1;
   logic sda_m = 1'b1;
   logic sda_ln, sda_oe, busy;

   int nchk = 0;
   int nfail = 0;
   int busy_hi = 0;

   always #10 clk = ~clk;

   assign sda_ln = sda_m & ~sda_oe;

   i2cm_slave #(.NV_CYCLES(NV)) u_i2cm_slave (
      .clk   (clk),
      .rst_n (rst_n),
      .scl_i (scl),
      .sda_i (sda_ln),
      .sda_oe(sda_oe),
      .busy  (busy)
   );

   always @(negedge clk) if (busy) busy_hi++;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic tk(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bus_start();
      if (!scl) begin
         sda_m = 1'b1; tk(Q); scl = 1'b1; tk(Q);
      end
      sda_m = 1'b0; tk(Q); scl = 1'b0; tk(Q);
   endtask

   task automatic bus_stop();
      sda_m = 1'b0; tk(Q); scl = 1'b1; tk(Q); sda_m = 1'b1; tk(Q);
   endtask

   task automatic put_bit(input bit b);
      sda_m = b; tk(Q); scl = 1'b1; tk(2*Q); scl = 1'b0; tk(Q);
   endtask

   task automatic get_bit(output bit b);
      sda_m = 1'b1; tk(Q); scl = 1'b1; tk(Q); b = sda_ln; tk(Q); scl = 1'b0; tk(Q);
   endtask

   task automatic send_byte(input logic [7:0] v, output bit ack);
      bit b;
      for (int i = 7; i >= 0; i--) put_bit(v[i]);
      get_bit(b);
      ack = !b;
   endtask

   task automatic recv_byte(input bit last, output logic [7:0] v, output bit rel);
      bit b;
      for (int i = 7; i >= 0; i--) begin
         get_bit(b);
         v[i] = b;
      end
      sda_m = last; tk(Q); scl = 1'b1; tk(Q); rel = !sda_oe; tk(Q); scl = 1'b0; tk(Q);
   endtask

   task automatic wait_idle();
      tk(10);
      while (busy) tk(1);
      tk(4);
   endtask

   function automatic logic [7:0] sel(input int hi, input bit rd);
      return {4'b1010, 3'(hi), rd};
   endfunction

   function automatic logic [7:0] pat(input int a);
      return 8'((a * 7 + 60) ^ ((a >> 8) << 5));
   endfunction

   task automatic set_ptr(input int a, input string req);
      bit ack;
      bus_start();
      send_byte(sel(a >> 8, 1'b0), ack);
      chk(ack, req, ack, 1);
      send_byte(8'(a), ack);
      chk(ack, req, ack, 1);
   endtask

   bit done = 1'b0;

   initial begin
      tk(150000);
      if (!done) begin
         nchk++;
         nfail++;
         $display("FAIL watchdog expired");
         $display("%0d/%0d checks passed", nchk - nfail, nchk);
         $finish;
      end
   end

   initial begin
      bit ack, rel, b;
      logic [7:0] v;
      int a;

      tk(5);
      // R1 reset state
      chk(sda_oe == 1'b0, "R1 sda_oe", sda_oe, 0);
      chk(busy == 1'b0, "R1 busy", busy, 0);
      rst_n = 1'b1;
      tk(5);

      // R11: valid select clocked without a start
      scl = 1'b0; tk(Q);
      send_byte(sel(0, 1'b0), ack);
      chk(!ack, "R11 no start", ack, 0);
      bus_stop();
      tk(20);

      // R2: sweep every wrong device nibble
      for (int n = 0; n < 16; n++) begin
         if (n == 10) continue;
         bus_start();
         send_byte({4'(n), 4'b0000}, ack);
         chk(!ack, "R2 bad nibble", ack, 0);
         send_byte(8'h00, ack);
         chk(!ack, "R2 idle after bad", ack, 0);
         bus_stop();
         tk(10);
      end
      chk(busy_hi == 0, "R10 no busy after rejects", busy_hi, 0);

      // R3 / R8: write three bytes in each upper-address bank
      for (int hi = 0; hi < 8; hi++) begin
         a = hi * 256 + ((hi * 37 + 5) & 8'hff);
         set_ptr(a, "R3 select/addr ack");
         for (int k = 0; k < 3; k++) begin
            send_byte(pat(a + k), ack);
            chk(ack, "R3 data ack", ack, 1);
         end
         busy_hi = 0;
         bus_stop();
         wait_idle();
         chk(busy_hi == NV, "R8 busy length", busy_hi, NV);
      end

      // R5 / R6 / R10: random read back of each bank
      for (int hi = 0; hi < 8; hi++) begin
         a = hi * 256 + ((hi * 37 + 5) & 8'hff);
         set_ptr(a, "R5 setup ack");
         bus_start();
         send_byte(sel(hi, 1'b1), ack);
         chk(ack, "R5 read select ack", ack, 1);
         for (int k = 0; k < 3; k++) begin
            recv_byte(k == 2, v, rel);
            chk(v == pat(a + k), "R5 read data", v, pat(a + k));
            chk(rel, "R5 release in ack clock", rel, 1);
         end
         busy_hi = 0;
         bus_stop();
         tk(30);
         chk(busy_hi == 0, "R10 no busy after read", busy_hi, 0);
      end

      // R4: address byte order seen through a neighbouring location
      set_ptr(1, "R4 setup");
      send_byte(8'h11, ack);
      send_byte(8'h22, ack);
      chk(ack, "R4 data ack", ack, 1);
      bus_stop();
      wait_idle();
      set_ptr(2, "R4 setup2");
      bus_start();
      send_byte(sel(0, 1'b1), ack);
      recv_byte(1'b1, v, rel);
      chk(v == 8'h22, "R4 msb first", v, 8'h22);
      bus_stop();
      tk(20);

      // R6: wrap from the top address on write and read
      set_ptr(2047, "R6 setup");
      send_byte(8'hA5, ack);
      send_byte(8'h3C, ack);
      chk(ack, "R6 wrap write ack", ack, 1);
      bus_stop();
      wait_idle();
      set_ptr(2047, "R6 setup2");
      bus_start();
      send_byte(sel(7, 1'b1), ack);
      recv_byte(1'b0, v, rel);
      chk(v == 8'hA5, "R6 top byte", v, 8'hA5);
      recv_byte(1'b1, v, rel);
      chk(v == 8'h3C, "R6 wrapped byte", v, 8'h3C);
      bus_stop();
      tk(20);
      set_ptr(0, "R6 setup3");
      bus_start();
      send_byte(sel(0, 1'b1), ack);
      recv_byte(1'b1, v, rel);
      chk(v == 8'h3C, "R6 address zero", v, 8'h3C);
      bus_stop();
      tk(20);

      // R7: after a master NACK nothing more is driven
      set_ptr(2, "R7 setup");
      bus_start();
      send_byte(sel(0, 1'b1), ack);
      recv_byte(1'b1, v, rel);
      chk(v == 8'h22, "R7 single byte", v, 8'h22);
      for (int i = 7; i >= 0; i--) begin
         get_bit(b);
         v[i] = b;
      end
      chk(v == 8'hFF, "R7 released after nack", v, 8'hFF);
      get_bit(b);
      chk(b == 1'b1, "R7 no ack driven", b, 1);
      bus_stop();
      tk(20);

      // R9: start during busy is ignored
      set_ptr(256, "R9 setup");
      send_byte(8'h77, ack);
      bus_stop();
      tk(5);
      chk(busy == 1'b1, "R9 busy running", busy, 1);
      bus_start();
      send_byte(sel(1, 1'b0), ack);
      chk(!ack, "R9 start ignored", ack, 0);
      chk(busy == 1'b1, "R9 still busy", busy, 1);
      bus_stop();
      wait_idle();
      bus_start();
      send_byte(sel(1, 1'b0), ack);
      chk(ack, "R9 accepted after busy", ack, 1);
      busy_hi = 0;
      bus_stop();
      tk(30);
      chk(busy_hi == 0, "R10 no busy without data", busy_hi, 0);

      done = 1'b1;
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
   end
endmodule